// File: doc/BRIEF.md
# Complementary Deadtime Gate Controller

This block sits in front of a half-bridge power stage. It turns one logic command into two drive signals. The high-side drive follows the command. The low-side drive is the inverse of the command. Neither drive may turn on until the other has been off for a programmed number of clock cycles. The same gap applies to both switching directions, and the path from a command edge to the first output change has the same length on both channels.

Two conditions force both drives low. The first is a shutdown request. The second is an undervoltage lockout, kept separately for the logic supply and for the floating supply. Each supply level arrives as an 8-bit code at 0.1 V per step, and each lockout has hysteresis. When a forcing condition clears, the block waits one full dead interval with both outputs low. It then turns on the side that the command selects.

The command and the shutdown request pass through a shared two-flop synchronizer before they reach the sequencing logic. The dead interval comes from a count input and is clamped into the legal range. With a 100 MHz clock, the value 50 gives 500 ns and the ceiling of 500 gives 5 µs.

Top module: `dt_gate_ctrl`

## Requirements
- R1: With no forcing condition, once the dead interval has run out, `hi_drv` equals the command `pwm_in` (1 = high side on) and `lo_drv` equals its inverse.
- R2: Before either output turns on, both outputs are low for exactly D consecutive cycles, where D is the clamped value of `dead_cfg`. This holds for both directions.
- R3: `hi_drv` and `lo_drv` are never 1 in the same cycle, for any input sequence.
- R4: While `sd_in` is 1, both outputs go low no later than the third rising clock edge after it is applied, and they stay low whatever `pwm_in` does.
- R5: Undervoltage on either supply channel forces both outputs low. Both channels start in lockout after reset.
- R6: The lockout for a channel releases when its code is 89 or more (8.9 V). Once released, it engages again only when the code drops below 82 (8.2 V). Codes 82 to 88 leave the current lockout state unchanged.
- R7: D is 1 when `dead_cfg` is 0, 500 when `dead_cfg` is above 500, and `dead_cfg` otherwise.
- R8: A command pulse shorter than D never turns on the opposite output. The side that was on comes back only after both outputs have been low for at least D cycles.
- R9: When shutdown or lockout clears, both outputs stay low for at least D cycles. Then the side selected by the current command turns on.
- R10: A command edge makes the side that was on turn off on the third rising clock edge after the change, in both directions. The other side turns on D edges after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Switching command; 1 selects the high side |
| sd_in | input | 1 | Shutdown request; 1 forces both outputs low |
| dead_cfg | input | DT_W | Requested dead interval in clock cycles |
| vcc_code | input | CODE_W | Logic supply level, 0.1 V per step |
| vbs_code | input | CODE_W | Floating supply level, 0.1 V per step |
| hi_drv | output | 1 | High-side drive |
| lo_drv | output | 1 | Low-side drive |

## Verification
The bench builds the block with its default parameters: a 10-bit count, a clamp range of 1 to 500, and lockout thresholds at codes 89 and 82. Because `dead_cfg` is a port, the bench can change it at run time. It uses the values 1, 4, 8 and 50, plus 0 and 700 to hit both clamp limits. At a dead interval of 1 the turn-off and turn-on edges fall on neighbouring cycles, so the exact latency counts are checked. At 500 the widest gap is checked, and it still ends after a few hundred cycles. The codes 81, 82, 88 and 89 sit on either side of each threshold, so every hysteresis boundary is checked against the edge it belongs to.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_HI   = 2'd1,
    SIDE_LO   = 2'd2
  } side_e;

  // Clamp a requested dead count into [lo, hi].
  function automatic int unsigned dt_clamp(input int unsigned raw,
                                           input int unsigned lo,
                                           input int unsigned hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

  // Next lockout state of one supply channel, with hysteresis.
  function automatic logic uv_next(input logic uv,
                                   input int unsigned code,
                                   input int unsigned rise,
                                   input int unsigned fall);
    if (uv) return (code < rise);
    return (code < fall);
  endfunction

endpackage

// File: rtl/dtg_sync2.sv
module dtg_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dtg_uvlo.sv
module dtg_uvlo #(
  parameter int CODE_W    = 8,
  parameter int RISE_CODE = 89,
  parameter int FALL_CODE = 82
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  output logic              uv
);
  import dtg_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uv <= 1'b1;
    else        uv <= uv_next(uv, int'(code), RISE_CODE, FALL_CODE);
  end
endmodule

// File: rtl/dtg_dead_core.sv
module dtg_dead_core #(
  parameter int DT_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            want,
  input  logic            fault,
  input  logic [DT_W-1:0] dt_eff,
  output logic            hi,
  output logic            lo
);
  import dtg_pkg::*;

  side_e           side;
  side_e           want_side;
  logic            want_q;
  logic [DT_W-1:0] cnt;
  logic [DT_W:0]   cnt_inc;
  logic            gap_done;

  assign want_side = want ? SIDE_HI : SIDE_LO;
  assign cnt_inc   = {1'b0, cnt} + 1'b1;
  assign gap_done  = (cnt_inc >= {1'b0, dt_eff});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      side   <= SIDE_NONE;
      cnt    <= '0;
      want_q <= 1'b0;
    end else begin
      want_q <= want;
      if (fault) begin
        side <= SIDE_NONE;
        cnt  <= '0;
      end else if (side != SIDE_NONE && side != want_side) begin
        side <= SIDE_NONE;
        cnt  <= '0;
      end else if (side == SIDE_NONE) begin
        if (want != want_q) begin
          cnt <= '0;
        end else if (gap_done) begin
          side <= want_side;
          cnt  <= '0;
        end else begin
          cnt <= cnt_inc[DT_W-1:0];
        end
      end
    end
  end

  assign hi = (side == SIDE_HI);
  assign lo = (side == SIDE_LO);
endmodule

// File: rtl/dt_gate_ctrl.sv
module dt_gate_ctrl #(
  parameter int DT_W      = 10,
  parameter int DT_MIN    = 1,
  parameter int DT_MAX    = 500,
  parameter int CODE_W    = 8,
  parameter int RISE_CODE = 89,
  parameter int FALL_CODE = 82
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_in,
  input  logic              sd_in,
  input  logic [DT_W-1:0]   dead_cfg,
  input  logic [CODE_W-1:0] vcc_code,
  input  logic [CODE_W-1:0] vbs_code,
  output logic              hi_drv,
  output logic              lo_drv
);
  import dtg_pkg::*;

  localparam int NCH = 2;

  logic [1:0]        sync_q;
  logic              pwm_s;
  logic              sd_s;
  logic [NCH-1:0]    uv;
  logic              fault;
  logic [DT_W-1:0]   dt_eff;
  logic [CODE_W-1:0] codes [NCH];

  dtg_sync2 #(.W(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sd_in, pwm_in}),
    .q    (sync_q)
  );
  assign pwm_s = sync_q[0];
  assign sd_s  = sync_q[1];

  assign codes[0] = vcc_code;
  assign codes[1] = vbs_code;

  for (genvar g = 0; g < NCH; g++) begin : g_uv
    dtg_uvlo #(
      .CODE_W   (CODE_W),
      .RISE_CODE(RISE_CODE),
      .FALL_CODE(FALL_CODE)
    ) u_uvlo (
      .clk  (clk),
      .rst_n(rst_n),
      .code (codes[g]),
      .uv   (uv[g])
    );
  end

  assign fault  = sd_s | (|uv);
  assign dt_eff = DT_W'(dt_clamp(int'(dead_cfg), DT_MIN, DT_MAX));

  dtg_dead_core #(.DT_W(DT_W)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .want  (pwm_s),
    .fault (fault),
    .dt_eff(dt_eff),
    .hi    (hi_drv),
    .lo    (lo_drv)
  );
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
  parameter int DT_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hi,
  input logic            lo,
  input logic            fault,
  input logic            want,
  input logic [DT_W-1:0] dt_eff
);
  logic [15:0] off_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             off_cnt <= '0;
    else if (hi || lo)      off_cnt <= '0;
    else if (off_cnt != '1) off_cnt <= off_cnt + 1'b1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi && lo)); // R3

  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!hi && !lo)); // R4

  AST_HI_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi) |-> want); // R1

  AST_LO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo) |-> !want); // R1

  AST_HI_AFTER_LO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi) |-> !$past(lo)); // R2

  AST_DEAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (($rose(hi) || $rose(lo)) && $stable(dt_eff)) |-> (off_cnt >= 16'(dt_eff))); // R2
endmodule

bind dt_gate_ctrl dtg_checker #(.DT_W(DT_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .hi    (hi_drv),
  .lo    (lo_drv),
  .fault (fault),
  .want  (pwm_s),
  .dt_eff(dt_eff)
);

// File: tb/dt_gate_ctrl_tb.sv
module dt_gate_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm_in = 1'b0;
  logic       sd_in = 1'b0;
  logic [9:0] dead_cfg = 10'd4;
  logic [7:0] vcc_code = 8'd120;
  logic [7:0] vbs_code = 8'd120;
  logic       hi_drv, lo_drv;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dt_gate_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .sd_in(sd_in),
    .dead_cfg(dead_cfg), .vcc_code(vcc_code), .vbs_code(vbs_code),
    .hi_drv(hi_drv), .lo_drv(lo_drv)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Count samples until the chosen side turns on; also count both-low run.
  task automatic wait_side(input bit want_hi, input int d, input string req);
    int low_run = 0;
    int found = -1;
    int bad = 0;
    for (int i = 1; i <= d + 12; i++) begin
      @(negedge clk);
      if (want_hi ? lo_drv : hi_drv) bad++;
      if ((want_hi ? hi_drv : lo_drv) && found < 0) found = i;
      if (found < 0 && !hi_drv && !lo_drv) low_run++;
    end
    check(found > 0, req, "selected side turned on", found, d);
    check(low_run >= d, req, "both-low run before turn-on", low_run, d);
    check(bad == 0, req, "opposite side stayed off", bad, 0);
  endtask

  // Exact timing of one command edge from a steady state.
  task automatic run_edge(input bit nv, input int d, input string req);
    int drop = -1;
    int rise = -1;
    int both = 0;
    @(negedge clk) pwm_in = nv;
    for (int i = 1; i <= d + 10; i++) begin
      @(negedge clk);
      if (hi_drv && lo_drv) both++;
      if (drop < 0 && !(nv ? lo_drv : hi_drv)) drop = i;
      if (rise < 0 && (nv ? hi_drv : lo_drv)) rise = i;
    end
    check(drop == 3, "R10", "turn-off latency", drop, 3);
    check(rise == 3 + d, req, "turn-on after dead interval", rise, 3 + d);
    check(both == 0, "R3", "overlap cycles", both, 0);
    check(hi_drv == nv && lo_drv == !nv, "R1", "steady outputs follow command",
          {hi_drv, lo_drv}, {nv, !nv});
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    tick(3);
    check(!hi_drv && !lo_drv, "R5", "outputs low in reset", {hi_drv, lo_drv}, 0);
    @(negedge clk) rst_n = 1'b1;
    wait_side(1'b0, 4, "R5");
  endtask

  task automatic test_edges();
    dead_cfg = 10'd4;
    run_edge(1'b1, 4, "R1");
    run_edge(1'b0, 4, "R1");
    dead_cfg = 10'd1;
    run_edge(1'b1, 1, "R2");
    run_edge(1'b0, 1, "R2");
    dead_cfg = 10'd50;
    run_edge(1'b1, 50, "R2");
    run_edge(1'b0, 50, "R2");
  endtask

  task automatic test_clamp();
    dead_cfg = 10'd0;
    run_edge(1'b1, 1, "R7");
    dead_cfg = 10'd700;
    run_edge(1'b0, 500, "R7");
  endtask

  task automatic test_pulse();
    int hi_seen = 0;
    int back = -1;
    int low_run = 0;
    dead_cfg = 10'd8;
    tick(4);
    @(negedge clk) pwm_in = 1'b1;
    tick(3);
    pwm_in = 1'b0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (hi_drv) hi_seen++;
      if (back < 0 && lo_drv && i > 3) back = i;
      if (back < 0 && !lo_drv && !hi_drv) low_run++;
    end
    check(hi_seen == 0, "R8", "opposite side during short pulse", hi_seen, 0);
    check(back > 0, "R8", "original side returned", back, 1);
    check(low_run >= 8, "R8", "gap before return", low_run, 8);
  endtask

  task automatic test_sd();
    int on_cnt = 0;
    @(negedge clk) sd_in = 1'b1;
    tick(3);
    check(!hi_drv && !lo_drv, "R4", "outputs low after shutdown", {hi_drv, lo_drv}, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      pwm_in = (i % 6) < 3;
      if (hi_drv || lo_drv) on_cnt++;
    end
    check(on_cnt == 0, "R4", "outputs held low while shut down", on_cnt, 0);
    @(negedge clk) pwm_in = 1'b1;
    sd_in = 1'b0;
    wait_side(1'b1, 8, "R9");
  endtask

  task automatic test_uv();
    int on_cnt = 0;
    @(negedge clk) vbs_code = 8'd82;
    tick(10);
    check(hi_drv == 1'b1, "R6", "code 82 keeps lockout released", hi_drv, 1);
    vbs_code = 8'd81;
    tick(3);
    check(!hi_drv && !lo_drv, "R5", "floating supply lockout", {hi_drv, lo_drv}, 0);
    vbs_code = 8'd88;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (hi_drv || lo_drv) on_cnt++;
    end
    check(on_cnt == 0, "R6", "code 88 keeps lockout engaged", on_cnt, 0);
    vbs_code = 8'd89;
    wait_side(1'b1, 8, "R6");
    @(negedge clk) vcc_code = 8'd70;
    tick(3);
    check(!hi_drv && !lo_drv, "R5", "logic supply lockout", {hi_drv, lo_drv}, 0);
    vcc_code = 8'd120;
    wait_side(1'b1, 8, "R9");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    test_reset();
    test_edges();
    test_clamp();
    test_pulse();
    test_sd();
    test_uv();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule